// File: doc/BRIEF.md
# Serial Variable-Length Register Port

This block is a slave register port for a three-wire serial link. An external controller drives an active-low select, a serial clock and a bidirectional data line. While select is low the controller shifts in a 4-bit address, then a direction bit, then a data field of any length from zero to 32 bits. The block decodes the address against a small register map in which each register has its own width. It stores the write data, returns read data, and steers the direction of the shared data line through a tri-state enable output.

All logic runs on a fast system clock. The three serial inputs pass through two-flop synchronizers, and the serial clock edges are found by an edge detector on the synchronized clock. A short write replaces only the top bits of the target register. An over-long write takes effect as soon as the register is full, and the surplus bits are dropped. Reads beyond a register's width yield zeros. Unmapped addresses yield a fixed run of ones followed by zeros. Two read-only words come from input ports. A one-bit write-only register restores every register to its default value.

Every accepted register update raises a one-cycle strobe together with the register's address, so that the surrounding logic can react.

Top module: `sreg_port`

## Requirements
- R1: While `sen_n` is high, toggling `sclk` and `sdio_in` has no effect: no strobe occurs, `sdio_oe` stays 0 and no register changes.
- R2: A frame starts when `sen_n` falls. Its bits are sampled on rising `sclk` edges in this order: 4 address bits with the MSB first, then a direction bit (1 = write, 0 = read), then data bits with the MSB first.
- R3: A write whose data length equals the register width takes effect when `sen_n` rises. At that point `commit_stb` pulses for one cycle with `commit_addr` equal to the address, and a later read returns the written value.
- R4: A write of k data bits, where k is at least 1 and less than the width L, replaces bits L-1 down to L-k with the received bits in order. The lower L-k bits keep their old values. A write with zero data bits changes nothing and raises no strobe.
- R5: A write longer than the register takes effect on the first rising `sclk` edge past the register width, while `sen_n` is still low. The bits beyond the width are ignored, and no second strobe follows when `sen_n` rises.
- R6: In a read, `sdio_out` changes after falling `sclk` edges and presents the register MSB first. `sdio_oe` is 0 up to and including the rising edge that samples the direction bit, becomes 1 after the falling edge that follows it, and returns to 0 once `sen_n` is high.
- R7: Read data bits beyond a register's width are 0.
- R8: A read of address 11 through 15 returns 1 for the first 32 data bits and 0 after that.
- R9: Address 5 (31 bits) reads `stat_in` and address 10 (32 bits) reads `wudata_in`. Writes to addresses 5, 10 and 12 through 15 are discarded and raise no strobe.
- R10: After reset, address 4 holds 0x10000270, address 6 holds 0x20, address 7 holds 0x7f8be110, address 8 holds 0x10208, and addresses 0 through 3 and 9 hold 0.
- R11: A write of at least one data bit to address 11 restores every stored register to its R10 value and raises a strobe with address 11.
- R12: The register widths are 32 bits for addresses 0 through 4, 7 and 10, 31 bits for address 5, 6 bits for address 6, 18 bits for address 8, 25 bits for address 9 and 1 bit for address 11.
- R13: A read abandoned before its last bit by raising `sen_n` leaves the registers unchanged, and the next frame is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst | input | 1 | Synchronous active-high reset |
| sen_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the controller |
| sdio_in | input | 1 | Data line value seen at the pad |
| sdio_out | output | 1 | Read data driven onto the line |
| sdio_oe | output | 1 | Drive enable for the data line |
| stat_in | input | 31 | Read-only status word at address 5 |
| wudata_in | input | 32 | Read-only data word at address 10 |
| commit_stb | output | 1 | One-cycle pulse per accepted register update |
| commit_addr | output | 4 | Address of the accepted update |

## Verification
The assertions assume that the serial inputs change slowly compared with `clk`. Each `sclk` level and each `sdio_in` value must hold for several system cycles, so that the synchronized data bit is settled at the detected rising edge. They also assume that `sen_n` only toggles while `sclk` is low. The bench drives `sclk` with 40 ns phases against a 5 ns system clock, and it changes `sdio_in` and `sen_n` only in the middle of the low phase. Random frames vary the address over all 16 values, the direction and the data length from 1 to 40 bits, so that short, exact and over-long accesses all occur.

// File: rtl/sreg_pkg.sv
`timescale 1ns/1ps
package sreg_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 4;
    localparam int unsigned CNT_W      = $clog2(DATA_W + 1);
    localparam int unsigned NREG       = 11;
    localparam logic [ADDR_W-1:0] STAT_ADDR  = 4'd5;
    localparam logic [ADDR_W-1:0] WDATA_ADDR = 4'd10;
    localparam logic [ADDR_W-1:0] RST_ADDR   = 4'd11;
    localparam logic [2:0] HDR_DATA = 3'd5;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [2:0]        hcnt;
        logic              rw;
        logic [CNT_W-1:0]  dcnt;
        logic              done;
        logic [DATA_W-1:0] shreg;
    } frame_t;

    localparam frame_t FRAME_IDLE = '{addr: '0, hcnt: '0, rw: 1'b0,
                                      dcnt: '0, done: 1'b0, shreg: '0};

    function automatic logic [CNT_W-1:0] reg_len(input logic [ADDR_W-1:0] a);
        case (a)
            4'd5:    return CNT_W'(31);
            4'd6:    return CNT_W'(6);
            4'd8:    return CNT_W'(18);
            4'd9:    return CNT_W'(25);
            4'd11:   return CNT_W'(1);
            default: return CNT_W'(DATA_W);
        endcase
    endfunction

    function automatic logic reg_writable(input logic [ADDR_W-1:0] a);
        return (a <= 4'd4) || (a >= 4'd6 && a <= 4'd9) || (a == RST_ADDR);
    endfunction

    function automatic logic reg_readable(input logic [ADDR_W-1:0] a);
        return a <= WDATA_ADDR;
    endfunction

    function automatic logic [DATA_W-1:0] reg_rstval(input logic [ADDR_W-1:0] a);
        case (a)
            4'd4:    return 32'h1000_0270;
            4'd6:    return 32'h0000_0020;
            4'd7:    return 32'h7f8b_e110;
            4'd8:    return 32'h0001_0208;
            default: return '0;
        endcase
    endfunction

    // Replace the top k of len bits with data (k bits, right aligned).
    function automatic logic [DATA_W-1:0] merge_top(input logic [DATA_W-1:0] old,
                                                    input logic [DATA_W-1:0] data,
                                                    input logic [CNT_W-1:0]  k,
                                                    input logic [CNT_W-1:0]  len);
        logic [CNT_W-1:0]  keep;
        logic [DATA_W-1:0] mask;
        keep = len - k;
        mask = (keep == '0) ? '0 : ((DATA_W'(1) << keep) - DATA_W'(1));
        return (old & mask) | (data << keep);
    endfunction

endpackage

// File: rtl/sreg_sync.sv
`timescale 1ns/1ps
module sreg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sen_n,
    input  logic sclk,
    input  logic sdi,
    output logic sen_s,
    output logic sen_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic din_s
);
    localparam logic [2:0] IDLE_V = 3'b100;

    logic [STAGES-1:0][2:0] stage_q;
    logic [2:0]             prev_q;
    logic [2:0]             cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= {STAGES{IDLE_V}};
            prev_q  <= IDLE_V;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], {sen_n, sclk, sdi}};
            prev_q  <= stage_q[STAGES-1];
        end
    end

    assign cur      = stage_q[STAGES-1];
    assign sen_s    = cur[2];
    assign din_s    = cur[0];
    assign sen_rise = cur[2] & ~prev_q[2];
    assign sck_rise = cur[1] & ~prev_q[1];
    assign sck_fall = ~cur[1] & prev_q[1];

endmodule

// File: rtl/sreg_frame.sv
`timescale 1ns/1ps
module sreg_frame
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sen_s,
    input  logic              sen_rise,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              din,
    input  logic              rd_ok,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  wr_cnt,
    output logic              sdo,
    output logic              oe
);
    frame_t st;

    assign rd_addr = st.addr;

    always_ff @(posedge clk) begin
        wr_stb <= 1'b0;
        if (rst) begin
            st      <= FRAME_IDLE;
            sdo     <= 1'b0;
            oe      <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_cnt  <= '0;
        end else if (sen_s) begin
            if (sen_rise && st.rw && !st.done && st.hcnt == HDR_DATA && st.dcnt != '0) begin
                wr_stb  <= 1'b1;
                wr_addr <= st.addr;
                wr_data <= st.shreg;
                wr_cnt  <= st.dcnt;
            end
            st  <= FRAME_IDLE;
            oe  <= 1'b0;
            sdo <= 1'b0;
        end else if (sck_rise) begin
            if (st.hcnt < 3'd4) begin
                st.addr <= {st.addr[ADDR_W-2:0], din};
                st.hcnt <= st.hcnt + 3'd1;
            end else if (st.hcnt == 3'd4) begin
                st.rw    <= din;
                st.hcnt  <= HDR_DATA;
                st.shreg <= din ? '0 : (rd_ok ? rd_word : '1);
            end else if (st.rw && !st.done) begin
                if (st.dcnt == reg_len(st.addr)) begin
                    wr_stb  <= 1'b1;
                    wr_addr <= st.addr;
                    wr_data <= st.shreg;
                    wr_cnt  <= st.dcnt;
                    st.done <= 1'b1;
                end else begin
                    st.shreg <= {st.shreg[DATA_W-2:0], din};
                    st.dcnt  <= st.dcnt + CNT_W'(1);
                end
            end
        end else if (sck_fall && st.hcnt == HDR_DATA && !st.rw) begin
            oe       <= 1'b1;
            sdo      <= st.shreg[DATA_W-1];
            st.shreg <= {st.shreg[DATA_W-2:0], 1'b0};
        end
    end

    // R6
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        sen_s |=> !oe);

    // R2
    oe_after_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (st.hcnt != HDR_DATA) |-> !oe);

    // R5
    commit_len_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (wr_cnt != '0 && wr_cnt <= reg_len(wr_addr)));

    // R1
    idle_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (sen_s && $past(sen_s)) |=> !wr_stb);

endmodule

// File: rtl/sreg_bank.sv
`timescale 1ns/1ps
module sreg_bank
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [30:0]       stat_in,
    input  logic [DATA_W-1:0] wudata_in,
    output logic              rd_ok,
    output logic [DATA_W-1:0] rd_word,
    output logic              commit_stb,
    output logic [ADDR_W-1:0] commit_addr
);
    logic [NREG-1:0][DATA_W-1:0] regs_flat;
    logic                        soft_rst;
    logic [DATA_W-1:0]           raw;

    assign soft_rst = wr_stb && (wr_addr == RST_ADDR);

    for (genvar g = 0; g < NREG; g++) begin : gen_reg
        localparam logic [ADDR_W-1:0] GA = ADDR_W'(g);
        localparam bit                WR = reg_writable(GA);
        if (WR) begin : gen_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst || soft_rst) begin
                    q <= reg_rstval(GA);
                end else if (wr_stb && wr_addr == GA) begin
                    q <= merge_top(q, wr_data, wr_cnt, reg_len(GA));
                end
            end
            assign regs_flat[g] = q;
        end else begin : gen_none
            assign regs_flat[g] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_stb  <= 1'b0;
            commit_addr <= '0;
        end else begin
            commit_stb <= wr_stb && reg_writable(wr_addr);
            if (wr_stb) commit_addr <= wr_addr;
        end
    end

    always_comb begin
        rd_ok = reg_readable(rd_addr);
        if (rd_addr == STAT_ADDR)       raw = {1'b0, stat_in};
        else if (rd_addr == WDATA_ADDR) raw = wudata_in;
        else if (rd_ok)                 raw = regs_flat[rd_addr];
        else                            raw = '0;
        rd_word = raw << (CNT_W'(DATA_W) - reg_len(rd_addr));
    end

    // R11
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (regs_flat[4] == reg_rstval(4'd4) && regs_flat[7] == reg_rstval(4'd7)));

    // R9
    ro_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        commit_stb |-> reg_writable(commit_addr));

    // R1
    hold_without_write_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(regs_flat));

endmodule

// File: rtl/sreg_port.sv
`timescale 1ns/1ps
module sreg_port
    import sreg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sen_n,
    input  logic        sclk,
    input  logic        sdio_in,
    output logic        sdio_out,
    output logic        sdio_oe,
    input  logic [30:0] stat_in,
    input  logic [31:0] wudata_in,
    output logic        commit_stb,
    output logic [3:0]  commit_addr
);
    logic              sen_s, sen_rise, sck_rise, sck_fall, din_s;
    logic              rd_ok;
    logic [DATA_W-1:0] rd_word;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [CNT_W-1:0]  wr_cnt;

    sreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sen_n    (sen_n),
        .sclk     (sclk),
        .sdi      (sdio_in),
        .sen_s    (sen_s),
        .sen_rise (sen_rise),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .din_s    (din_s)
    );

    sreg_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .sen_s    (sen_s),
        .sen_rise (sen_rise),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .din      (din_s),
        .rd_ok    (rd_ok),
        .rd_word  (rd_word),
        .rd_addr  (rd_addr),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_cnt   (wr_cnt),
        .sdo      (sdio_out),
        .oe       (sdio_oe)
    );

    sreg_bank u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_cnt      (wr_cnt),
        .rd_addr     (rd_addr),
        .stat_in     (stat_in),
        .wudata_in   (wudata_in),
        .rd_ok       (rd_ok),
        .rd_word     (rd_word),
        .commit_stb  (commit_stb),
        .commit_addr (commit_addr)
    );

endmodule

// File: tb/sreg_port_tb.sv
`timescale 1ns/1ps
module sreg_port_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sen_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo, oe, cstb;
    logic [3:0]  caddr;
    logic [30:0] stat = 31'h5123_4567;
    logic [31:0] wud  = 32'hC0DE_1234;

    int total = 0, fails = 0;
    int stb_cnt = 0, stb_low = 0;
    logic [3:0] last_addr = '0;
    bit finished = 0;
    logic [31:0] mdl [0:10];

    always #2.5 clk = ~clk;

    sreg_port u_dut (
        .clk(clk), .rst(rst), .sen_n(sen_n), .sclk(sclk), .sdio_in(sdi),
        .sdio_out(sdo), .sdio_oe(oe), .stat_in(stat), .wudata_in(wud),
        .commit_stb(cstb), .commit_addr(caddr)
    );

    always @(negedge clk) begin
        if (!rst && cstb) begin
            stb_cnt++;
            last_addr = caddr;
            if (!sen_n) stb_low++;
        end
    end

    function automatic int len_of(input logic [3:0] a);
        case (a)
            4'd5: return 31;
            4'd6: return 6;
            4'd8: return 18;
            4'd9: return 25;
            4'd11: return 1;
            default: return 32;
        endcase
    endfunction

    function automatic bit wr_ok(input logic [3:0] a);
        return (a <= 4) || (a >= 6 && a <= 9) || a == 11;
    endfunction

    function automatic logic [31:0] dflt(input int a);
        case (a)
            4: return 32'h1000_0270;
            6: return 32'h20;
            7: return 32'h7f8b_e110;
            8: return 32'h1_0208;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 11; i++) mdl[i] = dflt(i);
    endtask

    function automatic logic [39:0] exp_read(input logic [3:0] a, input int n);
        logic [39:0] r = '0;
        logic [31:0] v;
        int L = len_of(a);
        if (a == 5) v = {1'b0, stat};
        else if (a == 10) v = wud;
        else if (a <= 10) v = mdl[a];
        else v = '0;
        for (int j = 0; j < n; j++) begin
            if (a <= 10) r[n-1-j] = (j < L) ? v[L-1-j] : 1'b0;
            else         r[n-1-j] = (j < 32);
        end
        return r;
    endfunction

    // Model update for a write of n bits (MSB first in wd[n-1:0]).
    task automatic model_write(input logic [3:0] a, input int n, input logic [39:0] wd);
        int L = len_of(a);
        int k;
        logic [39:0] top;
        if (!wr_ok(a) || n < 1) return;
        if (a == 11) begin model_reset(); return; end
        k = (n < L) ? n : L;
        top = wd >> (n - k);
        for (int b = 0; b < k; b++) mdl[a][L-1-b] = top[k-1-b];
    endtask

    task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic send_bit(input logic b);
        sdi = b; #20; sclk = 1'b1; #40; sclk = 1'b0; #20;
    endtask

    // One access. rd collects read bits MSB-first; oe_pre is sdio_oe just
    // before the fall after the direction bit; oe_all is 1 if oe was high at
    // every read sample.
    task automatic frame(input logic [3:0] a, input logic rw, input int n,
                         input logic [39:0] wd, output logic [39:0] rd,
                         output logic oe_pre, output logic oe_all);
        rd = '0; oe_all = 1'b1;
        sen_n = 1'b0; #20;
        for (int i = 0; i < 4; i++) send_bit(a[3-i]);
        sdi = rw; #20; sclk = 1'b1; #40; oe_pre = oe; sclk = 1'b0; #20;
        for (int j = 0; j < n; j++) begin
            if (rw) send_bit(wd[n-1-j]);
            else begin
                #20; rd[n-1-j] = sdo; oe_all &= oe;
                sclk = 1'b1; #40; sclk = 1'b0; #20;
            end
        end
        #20; sen_n = 1'b1; #100;
    endtask

    task automatic do_write(input logic [3:0] a, input int n, input logic [39:0] wd);
        logic [39:0] rd; logic p, q;
        frame(a, 1'b1, n, wd, rd, p, q);
        model_write(a, n, wd);
    endtask

    task automatic check_read(input logic [3:0] a, input int n, input string req);
        logic [39:0] rd, e; logic p, q;
        frame(a, 1'b0, n, '0, rd, p, q);
        e = exp_read(a, n);
        chk(rd == e, req, rd, e);
    endtask

    initial begin
        #100000000;
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [39:0] rd, e;
        logic p, q;
        int s0, l0;
        void'($urandom(32'd5150));
        model_reset();
        repeat (8) @(posedge clk);
        rst = 1'b0;
        #1; #40;

        // R10 reset state
        chk(oe == 1'b0 && sdo == 1'b0, "R10 idle outputs", {38'd0, oe, sdo}, '0);
        check_read(4'd4, 32, "R10 addr4 default");
        check_read(4'd6, 6, "R10 addr6 default");
        check_read(4'd7, 32, "R10 addr7 default");
        check_read(4'd8, 18, "R10 addr8 default");
        check_read(4'd9, 25, "R12 R10 addr9 width");

        // R3 / R2 full-length write
        s0 = stb_cnt; l0 = stb_low;
        do_write(4'd0, 32, 40'hA5C3_0F12);
        chk(stb_cnt == s0 + 1 && stb_low == l0 && last_addr == 4'd0, "R3 strobe at enable rise",
            {stb_cnt - s0, stb_low - l0, last_addr}, {32'd1, 4'd0, 4'd0});
        check_read(4'd0, 32, "R3 R2 readback addr0");

        // R4 short write
        do_write(4'd4, 2, 40'h2);
        check_read(4'd4, 32, "R4 two-bit write addr4");
        chk(mdl[4] == 32'h9000_0270, "R4 model value", mdl[4], 40'h9000_0270);
        do_write(4'd6, 3, 40'h5);
        check_read(4'd6, 6, "R4 R12 three-bit write addr6");
        s0 = stb_cnt;
        do_write(4'd7, 0, '0);
        chk(stb_cnt == s0, "R4 zero-bit write no strobe", stb_cnt - s0, 0);

        // R5 over-long write
        s0 = stb_cnt; l0 = stb_low;
        do_write(4'd6, 10, 40'h2D7);
        chk(stb_cnt == s0 + 1 && stb_low == l0 + 1, "R5 early commit",
            {stb_cnt - s0, stb_low - l0}, {32'd1, 8'd1});
        check_read(4'd6, 6, "R5 extra bits ignored");

        // R6 direction control
        frame(4'd7, 1'b0, 8, '0, rd, p, q);
        chk(p == 1'b0, "R6 oe low at direction bit", p, 0);
        chk(q == 1'b1, "R6 oe high in data phase", q, 1);
        e = exp_read(4'd7, 8);
        chk(rd == e, "R6 MSB first", rd, e);
        chk(oe == 1'b0, "R6 oe released", oe, 0);

        // R7 past end
        check_read(4'd6, 12, "R7 zeros after addr6");
        check_read(4'd5, 34, "R7 R9 status past end");

        // R8 unmapped
        check_read(4'd13, 40, "R8 unmapped ones then zeros");
        check_read(4'd11, 36, "R8 write-only reads as unmapped");

        // R9 read-only
        s0 = stb_cnt;
        do_write(4'd5, 31, 40'h1234);
        do_write(4'd10, 32, 40'h1);
        do_write(4'd14, 8, 40'hFF);
        chk(stb_cnt == s0, "R9 no strobe for read-only", stb_cnt - s0, 0);
        check_read(4'd10, 32, "R9 addr10 data");

        // R1 idle toggling
        s0 = stb_cnt;
        for (int i = 0; i < 20; i++) begin
            sdi = i[0]; #20; sclk = 1'b1; #40; sclk = 1'b0; #20;
        end
        #100;
        chk(stb_cnt == s0 && oe == 1'b0, "R1 idle toggles ignored", {stb_cnt - s0, oe}, 0);
        check_read(4'd0, 32, "R1 addr0 unchanged");

        // R13 abandoned read
        frame(4'd7, 1'b0, 3, '0, rd, p, q);
        e = exp_read(4'd7, 3);
        chk(rd == e, "R13 partial read", rd, e);
        check_read(4'd7, 32, "R13 following read");

        // R11 soft reset
        do_write(4'd1, 32, 40'hDEAD_BEEF);
        s0 = stb_cnt;
        do_write(4'd11, 1, 40'h0);
        chk(stb_cnt == s0 + 1 && last_addr == 4'd11, "R11 strobe addr11",
            {stb_cnt - s0, last_addr}, {32'd1, 4'd11});
        check_read(4'd1, 32, "R11 addr1 cleared");
        check_read(4'd4, 32, "R11 addr4 default");

        // Random frames
        for (int it = 0; it < 60; it++) begin
            logic [3:0] a;
            int n;
            logic [39:0] wd;
            a = 4'($urandom % 16);
            n = 1 + int'($urandom % 40);
            wd = {8'($urandom), 32'($urandom)};
            if ($urandom % 2) begin
                s0 = stb_cnt;
                do_write(a, n, wd);
                chk(stb_cnt == s0 + (wr_ok(a) ? 1 : 0), "R3 R9 random write strobe",
                    stb_cnt - s0, wr_ok(a));
            end else begin
                check_read(a, n, "R7 R8 R12 random read");
            end
        end
        check_read(4'd4, 32, "R4 final addr4");
        check_read(4'd8, 18, "R12 final addr8");

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule